// File: doc/BRIEF.md
# Sync-Interval Mean and Power Monitor

This block watches one wideband sample stream that delivers four signed samples on every clock. Over each interval between two stream syncs it adds up the samples and the squares of the samples, each into a 64-bit accumulator. When the next sync arrives, the two totals are frozen into result registers. The accumulators then start again from the samples of the sync beat itself. Software reads the frozen totals through a four-word register port. From them it derives the mean (DC offset) and the power of the signal over a known interval.

The same sync also starts a snapshot capture. The sync beat and the beats after it are written, one data word per beat, into a buffer of 4096 samples. Writing stops once the buffer is full and resumes at the next sync. A separate read port gives random access to the buffer words, so the raw waveform that produced a set of statistics can be inspected.

Top module: `syncStatMonitor`

## Requirements
- R1: While `rst` is high, both result registers clear to zero, and register reads return 0 after reset.
- R2: A beat with `inValid` and `inSync` both high freezes the totals of all valid beats since the previous sync beat, without the sync beat's own samples, into the result registers one cycle later. The accumulators restart with that sync beat's samples.
- R3: The sample total is the two's-complement 64-bit sum of all four signed 8-bit lanes of every counted beat.
- R4: The power total is the 64-bit sum of the squares of all four signed lanes of every counted beat, taken at full precision, so -128 squares to 16384.
- R5: Register read data is registered one cycle after `regAddr`. Address 0 returns sample-total bits 31:0, 1 returns bits 63:32, 2 returns power-total bits 31:0, and 3 returns bits 63:32.
- R6: The result registers hold their values unchanged between two sync beats.
- R7: Beats with `inValid` low are ignored completely, whatever their data, and so is a sync that is raised while `inValid` is low.
- R8: `inData[31:24]` carries the earliest sample of a beat and `inData[7:0]` the latest. The lanes in between follow in time order.
- R9: A valid sync beat is written to buffer word 0. The following valid beats go to words 1, 2 and so on up to word 1023. Further beats are not written until the next sync. Words keep the input packing, earliest sample in bits 31:24.
- R10: `ramRdData` returns the buffer word at `ramAddr` one cycle later.
- R11: The test signal is a full-scale sine at one-sixteenth of the sample rate, with amplitude 127 and starting at phase zero. Over an interval of 49152 samples, this signal gives a sample total of exactly 0 and a power total of exactly 396343296.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data-path clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input beat carries four valid samples |
| inSync | input | 1 | Beat starts a new statistics interval (counted only with inValid) |
| inData | input | 32 | Four packed signed 8-bit samples, earliest in bits 31:24 |
| regAddr | input | 2 | Result word select |
| regRdData | output | 32 | Selected result word, one cycle after regAddr |
| ramAddr | input | 10 | Snapshot buffer word address |
| ramRdData | output | 32 | Snapshot buffer word, one cycle after ramAddr |

## Verification
Three latencies matter here. The result registers change one clock edge after the sync beat is sampled. A register read then takes one more edge, so a total becomes visible on `regRdData` two edges after its closing sync. A buffer word appears on `ramRdData` one edge after its address. The bench drives every input on the falling edge. It reads a port value only on the falling edge that follows the edge that registered it. This makes the sync-to-read distance exactly two edges. While reads are in progress the stream stays idle, with junk data and `inValid` low, so a read never shifts which beats fall into an interval.

// File: rtl/statMonPkg.sv
package statMonPkg;

  // Per-beat commands from the control unit to the datapath
  typedef struct packed {
    logic restart;   // valid sync beat: freeze totals, restart accumulators
    logic accum;     // valid beat: fold lanes into accumulators
    logic bufWr;     // write this beat into the snapshot buffer
  } monStrobe_t;

endpackage

// File: rtl/statMonCtrl.sv
module statMonCtrl
  import statMonPkg::*;
#(
  parameter int BUF_WORDS = 1024,
  localparam int BUF_AW = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSync,
  output monStrobe_t        strobe,
  output logic [BUF_AW-1:0] bufAddr
);

  logic [BUF_AW-1:0] wrPtr;
  logic              filling;

  always_comb begin
    strobe.restart = inValid & inSync;
    strobe.accum   = inValid;
    strobe.bufWr   = inValid & (inSync | filling);
    bufAddr        = inSync ? '0 : wrPtr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      filling <= 1'b0;
    end else if (inValid) begin
      if (inSync) begin
        wrPtr   <= BUF_AW'(1);
        filling <= (BUF_WORDS > 1);
      end else if (filling) begin
        wrPtr <= wrPtr + 1'b1;
        if (wrPtr == BUF_AW'(BUF_WORDS - 1)) filling <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/statMonDatapath.sv
module statMonDatapath
  import statMonPkg::*;
#(
  parameter int LANES     = 4,
  parameter int SAMP_W    = 8,
  parameter int ACC_W     = 64,
  parameter int REG_W     = 32,
  parameter int BUF_WORDS = 1024,
  localparam int DATA_W = LANES * SAMP_W,
  localparam int BUF_AW = $clog2(BUF_WORDS),
  localparam int SQ_W   = 2 * SAMP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  monStrobe_t               strobe,
  input  logic [BUF_AW-1:0]        bufAddr,
  input  logic [DATA_W-1:0]        inData,
  input  logic [1:0]               regAddr,
  output logic [REG_W-1:0]         regRdData,
  input  logic [BUF_AW-1:0]        ramAddr,
  output logic [DATA_W-1:0]        ramRdData,
  output logic signed [ACC_W-1:0]  sumRes,
  output logic [ACC_W-1:0]         powRes
);

  logic signed [SAMP_W-1:0] laneVal [LANES];
  logic        [SQ_W-1:0]   laneSq  [LANES];

  // Lane 0 is the earliest sample and sits in the top bits
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneVal[i] = inData[(LANES-i)*SAMP_W-1 -: SAMP_W];
    logic signed [SQ_W-1:0] prod;
    assign prod      = laneVal[i] * laneVal[i];
    assign laneSq[i] = prod;  // never negative, fits without the sign bit
  end

  logic signed [ACC_W-1:0] beatSum;
  logic        [ACC_W-1:0] beatPow;

  always_comb begin
    beatSum = '0;
    beatPow = '0;
    for (int i = 0; i < LANES; i++) begin
      beatSum += {{(ACC_W-SAMP_W){laneVal[i][SAMP_W-1]}}, laneVal[i]};
      beatPow += {{(ACC_W-SQ_W){1'b0}}, laneSq[i]};
    end
  end

  logic signed [ACC_W-1:0] sumAcc;
  logic        [ACC_W-1:0] powAcc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumAcc <= '0;
      powAcc <= '0;
      sumRes <= '0;
      powRes <= '0;
    end else if (strobe.restart) begin
      sumRes <= sumAcc;
      powRes <= powAcc;
      sumAcc <= beatSum;
      powAcc <= beatPow;
    end else if (strobe.accum) begin
      sumAcc <= sumAcc + beatSum;
      powAcc <= powAcc + beatPow;
    end
  end

  // Result word readout
  always_ff @(posedge clk) begin
    if (rst) regRdData <= '0;
    else begin
      case (regAddr)
        2'd0:    regRdData <= sumRes[REG_W-1:0];
        2'd1:    regRdData <= sumRes[ACC_W-1:REG_W];
        2'd2:    regRdData <= powRes[REG_W-1:0];
        default: regRdData <= powRes[ACC_W-1:REG_W];
      endcase
    end
  end

  // Snapshot buffer
  logic [DATA_W-1:0] snapMem [BUF_WORDS];

  always_ff @(posedge clk) begin
    if (strobe.bufWr) snapMem[bufAddr] <= inData;
    ramRdData <= snapMem[ramAddr];
  end

endmodule

// File: rtl/syncStatMonitor.sv
module syncStatMonitor
  import statMonPkg::*;
#(
  parameter int LANES       = 4,
  parameter int SAMP_W      = 8,
  parameter int ACC_W       = 64,
  parameter int REG_W       = 32,
  parameter int BUF_SAMPLES = 4096,
  localparam int DATA_W    = LANES * SAMP_W,
  localparam int BUF_WORDS = BUF_SAMPLES / LANES,
  localparam int BUF_AW    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSync,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        regAddr,
  output logic [REG_W-1:0]  regRdData,
  input  logic [BUF_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramRdData
);

  monStrobe_t              strobe;
  logic [BUF_AW-1:0]       bufAddr;
  logic signed [ACC_W-1:0] sumRes;
  logic [ACC_W-1:0]        powRes;

  statMonCtrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inSync  (inSync),
    .strobe  (strobe),
    .bufAddr (bufAddr)
  );

  statMonDatapath #(
    .LANES(LANES), .SAMP_W(SAMP_W), .ACC_W(ACC_W),
    .REG_W(REG_W), .BUF_WORDS(BUF_WORDS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .bufAddr   (bufAddr),
    .inData    (inData),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .ramAddr   (ramAddr),
    .ramRdData (ramRdData),
    .sumRes    (sumRes),
    .powRes    (powRes)
  );

endmodule

// File: rtl/syncStatMonitorChecker.sv
module syncStatMonitorChecker
  import statMonPkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int REG_W  = 32,
  parameter int BUF_AW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inSync,
  input logic [1:0]        regAddr,
  input logic [REG_W-1:0]  regRdData,
  input monStrobe_t        strobe,
  input logic [BUF_AW-1:0] bufAddr,
  input logic [ACC_W-1:0]  sumRes,
  input logic [ACC_W-1:0]  powRes
);

  // R1: reset clears the frozen totals
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sumRes == '0 && powRes == '0));

  // R6: totals only move on a valid sync beat
  a_r6_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
    !(inValid && inSync) |=> ($stable(sumRes) && $stable(powRes)));

  // R4: a sum of squares never goes negative
  a_r4_power_nonneg: assert property (@(posedge clk) disable iff (rst)
    powRes[ACC_W-1] == 1'b0);

  // R5: word 0 of the map is the low half of the sample total
  a_r5_read_word0: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd0) |=> (regRdData == $past(sumRes[REG_W-1:0])));

  // R9: a valid sync beat lands in buffer word 0
  a_r9_sync_word0: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSync) |-> (strobe.bufWr && bufAddr == '0));

  // R7: nothing is written without a valid beat
  a_r7_no_write_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> !strobe.bufWr);

endmodule

bind syncStatMonitor syncStatMonitorChecker #(
  .ACC_W(ACC_W), .REG_W(REG_W), .BUF_AW(BUF_AW)
) chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inSync    (inSync),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .strobe    (strobe),
  .bufAddr   (bufAddr),
  .sumRes    (sumRes),
  .powRes    (powRes)
);

// File: tb/syncStatMonitor_test.sv
module syncStatMonitor_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inSync = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regRdData;
  logic [9:0]  ramAddr = '0;
  logic [31:0] ramRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  syncStatMonitor uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSync(inSync), .inData(inData),
    .regAddr(regAddr), .regRdData(regRdData), .ramAddr(ramAddr), .ramRdData(ramRdData)
  );

  typedef struct packed {
    logic [7:0]  l0, l1, l2, l3;
    int          n;
    longint      sumExp;
    longint      powExp;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{8'd1,   8'd2,   8'd3,   8'd4,   5, 64'sd50,    64'sd150},
    '{8'h80,  8'h80,  8'h80,  8'h80,  3, -64'sd1536, 64'sd196608},
    '{8'd127, 8'h80,  8'd127, 8'h80,  7, -64'sd14,   64'sd455182},
    '{8'd0,   8'd0,   8'd0,   8'hFF,  1, -64'sd1,    64'sd1}
  };

  task automatic check64(input string req, input longint act, input longint exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic s, input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; inSync = s; inData = d;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0; inData = 32'hA5C3_7E81;  // junk while idle (R7)
    regAddr = a;
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic readRes(output longint s, output longint p);
    logic [31:0] w0, w1, w2, w3;
    readReg(2'd0, w0); readReg(2'd1, w1);
    readReg(2'd2, w2); readReg(2'd3, w3);
    s = longint'({w1, w0});
    p = longint'({w3, w2});
  endtask

  task automatic readRam(input int a, output logic [31:0] v);
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0;
    ramAddr = 10'(a);
    @(negedge clk);
    v = ramRdData;
  endtask

  function automatic logic [7:0] sineAt(input int ph);
    case (ph % 16)
      0, 8:  return 8'd0;
      1, 7:  return 8'd49;
      2, 6:  return 8'd90;
      3, 5:  return 8'd117;
      4:     return 8'd127;
      9, 15: return 8'hCF;   // -49
      10, 14: return 8'hA6;  // -90
      11, 13: return 8'h8B;  // -117
      default: return 8'h81; // -127
    endcase
  endfunction

  function automatic logic [31:0] sineWord(input int k);
    return {sineAt(4*k), sineAt(4*k+1), sineAt(4*k+2), sineAt(4*k+3)};
  endfunction

  function automatic logic [31:0] cntWord(input int j);
    logic [7:0] lo;
    lo = 8'(j);
    return {lo, 8'(j >> 8), 8'h5A, ~lo};
  endfunction

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    longint s, p, s2, p2;
    logic [31:0] w;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    readRes(s, p);
    check64("R1 sum after reset", s, 0);
    check64("R1 power after reset", p, 0);

    // R2 R3 R4 R5 R8: walk the vector table, one interval per entry
    for (int i = 0; i <= NV; i++) begin
      if (i < NV) beat(1'b1, {VECS[i].l0, VECS[i].l1, VECS[i].l2, VECS[i].l3});
      else        beat(1'b1, 32'h0);
      if (i > 0) begin
        readRes(s, p);
        check64("R3 vector sample total", s, VECS[i-1].sumExp);
        check64("R4 vector power total", p, VECS[i-1].powExp);
      end else begin
        readRes(s, p);
        check64("R2 first sync freezes empty interval", s, 0);
      end
      if (i < NV)
        for (int k = 1; k < VECS[i].n; k++)
          beat(1'b0, {VECS[i].l0, VECS[i].l1, VECS[i].l2, VECS[i].l3});
    end

    // R7 + R6: sync with valid low is ignored, results hold mid-interval
    beat(1'b1, 32'h01010101);
    beat(1'b0, 32'h01010101);
    readRes(s, p);                        // previous interval: the zero sync beat alone
    check64("R2 zero-beat interval", s, 0);
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b1; inData = 32'h7F7F7F7F;
    beat(1'b0, 32'h01010101);
    readRes(s2, p2);
    check64("R6 results held after invalid sync", s2, s);
    check64("R7 power held after invalid sync", p2, p);
    beat(1'b0, 32'h01010101);
    beat(1'b1, 32'h0);
    readRes(s, p);
    check64("R7 sum ignores idle beats", s, 16);
    check64("R7 power ignores idle beats", p, 16);

    // R11 + R9: full-scale sine over 49152 samples
    beat(1'b1, sineWord(0));
    for (int j = 1; j < 12288; j++) beat(1'b0, sineWord(j));
    readRam(0, w);    check64("R9 buffer word 0 holds sync beat", longint'(w), longint'(sineWord(0)));
    readRam(1, w);    check64("R8 buffer word 1 lane order", longint'(w), longint'(sineWord(1)));
    readRam(1023, w); check64("R10 buffer last word", longint'(w), longint'(sineWord(1023)));
    beat(1'b1, 32'h0);
    readRes(s, p);
    check64("R11 sine sample total", s, 0);
    check64("R11 sine power total", p, 64'sd396343296);

    // R9: writes stop at word 1023 until the next sync
    beat(1'b1, cntWord(0));
    for (int j = 1; j < 1100; j++) beat(1'b0, cntWord(j));
    readRam(0, w);    check64("R9 word 0 not overwritten after full", longint'(w), longint'(cntWord(0)));
    readRam(2, w);    check64("R10 buffer word 2", longint'(w), longint'(cntWord(2)));
    readRam(1023, w); check64("R9 final written word", longint'(w), longint'(cntWord(1023)));

    // R1: reset mid-run clears results
    beat(1'b1, 32'h10101010);
    readRes(s, p);
    check64("R2 counter interval nonzero", (p != 0) ? 1 : 0, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    readRes(s, p);
    check64("R1 sum cleared by reset", s, 0);
    check64("R1 power cleared by reset", p, 0);

    report();
  end

endmodule